// File: doc/BRIEF.md
# Deferrable Interrupt Aggregation Timer

This block merges eight event sources into a single active-low interrupt line. Every source has a sticky flag that is set by a one-cycle pulse and remains set until it is cleared. Each source also has an enable bit, and only enabled flags can take part in driving the interrupt. The sources fall into two classes. The two critical sources, a supply or thermal fault and an overcurrent fault, pull the interrupt low immediately. The six deferrable sources can be held back by a hold-off window. These are start fault, classification done, detection done, disconnect, power-good change and power-enable change.

A 4-bit selector sets the hold-off window as a number of 10 ms steps, from 1 to 15. A prescaler produces those steps from the system clock, and its divide ratio is a parameter. The window starts when an enabled deferrable flag first appears while no window is running. When the window ends, the deferrable flags are released to the interrupt line. They stay released until every enabled deferrable flag has been cleared. A selector value of zero turns deferral off, so deferrable sources then behave like critical ones.

Top module: `irq_holdoff_agg`

## Requirements
- R1: Each bit of `evt_flags` is sticky. It is set in the cycle after its `evt_pulse` bit is high, and it is cleared in the cycle after its `flag_clr` bit is high. When a bit is pulsed and cleared in the same cycle, the set wins.
- R2: While `rst_n` is low at a clock edge, all flags are cleared, `irq_n` is driven high (deasserted) and the hold-off controller returns to idle with no window length stored.
- R3: Bits 0 (supply/thermal fault) and 1 (overcurrent fault) are critical. When such a bit is set and enabled in `evt_en`, `irq_n` is low in the same cycle that the flag is visible, which is one clock after the pulse.
- R4: Bits 2 to 7 are deferrable. With `hold_sel` = N (N > 0) and the block idle, an enabled deferrable pulse sampled at edge E0 drives `irq_n` low only after edge E0 + 1 + N·TICK_DIV. Before that edge, `irq_n` stays high unless a critical flag is active.
- R5: When `hold_sel` is 0 and no window is running, an enabled deferrable flag drives `irq_n` low one clock after its pulse, which is the same latency as a critical flag.
- R6: The enable mask works the same way in both classes. A disabled flag still latches in `evt_flags`, but it never drives `irq_n` and never starts a hold-off window.
- R7: After release, `irq_n` follows the enabled deferrable flags with no further delay. Once every enabled deferrable flag is cleared, the controller returns to idle, and the next deferrable event waits a full new window.
- R8: A change of `hold_sel` while a window is running does not change the length of that window. The new value applies from the next window onward.
- R9: `irq_n` is low only while at least one enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 8 | One-cycle event pulses; bits 0-1 critical, bits 2-7 deferrable |
| evt_en | input | 8 | Per-event enable mask |
| hold_sel | input | 4 | Hold-off window in prescaler steps; 0 disables deferral |
| flag_clr | input | 8 | Per-flag clear strobes |
| evt_flags | output | 8 | Latched event flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest situation to reach from the ports is a `hold_sel` change in the middle of a running window. It only matters when the window is long enough to span the change and nothing clears the pending flag before the window ends. A directed sequence starts a four-step window, moves the selector to one step partway through, and measures the exact cycle at which the interrupt asserts. A cycle-accurate bench model runs alongside the random phase. It cross-checks windows that are cut short by clears, windows that are restarted, and enable changes during a window.

// File: rtl/irq_holdoff_pkg.sv
// Package: shared constants and types for the deferrable interrupt aggregator.
// Assumes a fixed event map of eight sources; the two lowest are critical.
package irq_holdoff_pkg;

    localparam int EVT_W = 8;

    // Bit positions of the event sources (fixed map decoded by software)
    localparam int EV_SUPPLY  = 0;
    localparam int EV_OVERCUR = 1;
    localparam int EV_STARTF  = 2;
    localparam int EV_CLASS   = 3;
    localparam int EV_DETECT  = 4;
    localparam int EV_DISCON  = 5;
    localparam int EV_PGOOD   = 6;
    localparam int EV_PWREN   = 7;

    // Class mask: 1 = critical (never deferred), 0 = deferrable
    localparam logic [EVT_W-1:0] CRIT_BITS =
        (EVT_W'(1) << EV_SUPPLY) | (EVT_W'(1) << EV_OVERCUR);
    localparam logic [EVT_W-1:0] DEFER_BITS = ~CRIT_BITS;

    // Hold-off controller states
    typedef enum logic [1:0] {
        HO_IDLE    = 2'd0,
        HO_COUNT   = 2'd1,
        HO_RELEASE = 2'd2
    } ho_state_e;

endpackage

// File: rtl/irq_flag_bank.sv
// Module: bank of sticky event flags.
// Each flag sets on its pulse and clears on its clear strobe; set has priority.
// Assumes pulses are synchronous to clk.
module irq_flag_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_cell
            logic flag_q;

            // Purpose: hold one sticky flag, set wins over clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (set_i[gi]) begin
                    flag_q <= 1'b1;
                end else if (clr_i[gi]) begin
                    flag_q <= 1'b0;
                end
            end

            assign flag_o[gi] = flag_q;
        end
    endgenerate

endmodule

// File: rtl/irq_tick_gen.sv
// Module: step prescaler for the hold-off window.
// Produces a one-cycle tick every TICK_DIV cycles while run_i is high.
// The count restarts from zero whenever run_i is low, which aligns each
// window to the cycle in which it starts.
module irq_tick_gen #(
    parameter int TICK_DIV = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int PW = $clog2(TICK_DIV + 1);
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] div_q;

    // Purpose: count clock cycles within one step while running
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = run_i && (div_q == LAST);

endmodule

// File: rtl/irq_holdoff_fsm.sv
// Module: hold-off window controller.
// Starts a window when deferrable work is pending and the controller is idle.
// The window length is captured at start, so later selector changes apply
// to the next window only. Releases the deferrable flags when the window
// ends, and returns to idle once nothing deferrable is pending.
// A zero selector means no deferral.
module irq_holdoff_fsm
    import irq_holdoff_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic             release_o
);

    ho_state_e        state_q;
    logic [SEL_W-1:0] win_q;
    logic [SEL_W-1:0] step_q;
    logic             sel_zero;

    assign sel_zero = (sel_i == '0);

    // Purpose: state transitions, window capture and step counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HO_IDLE;
            win_q   <= '0;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                HO_IDLE: begin
                    step_q <= '0;
                    if (pend_i) begin
                        if (sel_zero) begin
                            state_q <= HO_RELEASE;
                        end else begin
                            state_q <= HO_COUNT;
                            win_q   <= sel_i;
                        end
                    end
                end
                HO_COUNT: begin
                    if (!pend_i) begin
                        state_q <= HO_IDLE;
                    end else if (tick_i) begin
                        if (step_q == win_q - 1'b1) begin
                            state_q <= HO_RELEASE;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                HO_RELEASE: begin
                    if (!pend_i) begin
                        state_q <= HO_IDLE;
                    end
                end
                default: state_q <= HO_IDLE;
            endcase
        end
    end

    assign run_o     = (state_q == HO_COUNT);
    assign release_o = (state_q == HO_RELEASE) ||
                       ((state_q == HO_IDLE) && sel_zero);

endmodule

// File: rtl/irq_holdoff_agg.sv
// Module: top of the deferrable interrupt aggregator.
// Combines eight sticky event flags under an enable mask into one
// active-low interrupt. Critical flags act at once; deferrable flags wait
// for the hold-off window. TICK_DIV is the number of clock cycles in one
// 10 ms step (1,250,000 at 125 MHz).
module irq_holdoff_agg
    import irq_holdoff_pkg::*;
#(
    parameter int TICK_DIV = 1250000,
    parameter int SEL_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_pulse,
    input  logic [EVT_W-1:0] evt_en,
    input  logic [SEL_W-1:0] hold_sel,
    input  logic [EVT_W-1:0] flag_clr,
    output logic [EVT_W-1:0] evt_flags,
    output logic             irq_n
);

    logic [EVT_W-1:0] live;
    logic             crit_any;
    logic             defer_any;
    logic             hold_run;
    logic             step_tick;
    logic             def_release;

    irq_flag_bank #(.WIDTH(EVT_W)) flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_pulse),
        .clr_i  (flag_clr),
        .flag_o (evt_flags)
    );

    // Purpose: split the enabled flags into the two classes
    always_comb begin
        live      = evt_flags & evt_en;
        crit_any  = |(live & CRIT_BITS);
        defer_any = |(live & DEFER_BITS);
    end

    irq_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (hold_run),
        .tick_o (step_tick)
    );

    irq_holdoff_fsm #(.SEL_W(SEL_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (defer_any),
        .sel_i     (hold_sel),
        .tick_i    (step_tick),
        .run_o     (hold_run),
        .release_o (def_release)
    );

    // Purpose: drive the active-low request from both classes
    always_comb begin
        irq_n = !(crit_any || (defer_any && def_release));
    end

endmodule

// File: rtl/irq_holdoff_chk.sv
// Module: assertion checker for irq_holdoff_agg, attached by bind.
// Observes ports plus the controller's run and release signals.
module irq_holdoff_chk
    import irq_holdoff_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EVT_W-1:0] evt_pulse,
    input logic [EVT_W-1:0] evt_en,
    input logic [SEL_W-1:0] hold_sel,
    input logic [EVT_W-1:0] flag_clr,
    input logic [EVT_W-1:0] evt_flags,
    input logic             irq_n,
    input logic             hold_run,
    input logic             def_release
);

    assert_reset_clears_R2: assert property (@(posedge clk)
        !rst_n |=> (evt_flags == '0 && irq_n));

    assert_pulse_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((evt_flags & $past(evt_pulse)) == $past(evt_pulse)));

    assert_flag_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_flags & ~flag_clr)) |=>
            ((evt_flags & $past(evt_flags & ~flag_clr)) == $past(evt_flags & ~flag_clr)));

    assert_crit_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_flags & evt_en & CRIT_BITS)) |-> !irq_n);

    assert_defer_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!def_release && !(|(evt_flags & evt_en & CRIT_BITS))) |-> irq_n);

    assert_zero_sel_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_sel == '0 && !hold_run && (|(evt_flags & evt_en & DEFER_BITS))) |-> !irq_n);

    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|(evt_flags & evt_en)));

endmodule

bind irq_holdoff_agg irq_holdoff_chk #(.SEL_W(SEL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse   (evt_pulse),
    .evt_en      (evt_en),
    .hold_sel    (hold_sel),
    .flag_clr    (flag_clr),
    .evt_flags   (evt_flags),
    .irq_n       (irq_n),
    .hold_run    (hold_run),
    .def_release (def_release)
);

// File: tb/irq_holdoff_agg_tb_top.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a cycle-level model built from the requirements.
module irq_holdoff_agg_tb_top;

    localparam int DIV = 5;
    localparam logic [7:0] CRIT = 8'b0000_0011;
    localparam logic [7:0] DEFR = 8'b1111_1100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_pulse = '0;
    logic [7:0] evt_en = '0;
    logic [3:0] hold_sel = '0;
    logic [7:0] flag_clr = '0;
    logic [7:0] evt_flags;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    irq_holdoff_agg #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_en(evt_en),
        .hold_sel(hold_sel), .flag_clr(flag_clr), .evt_flags(evt_flags), .irq_n(irq_n)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_flags = '0;
    int         m_phase = 0;   // 0 idle, 1 counting, 2 released
    int         m_start = 0;
    int         m_win = 0;
    int         cyc = 0;

    function automatic logic model_irq_n(logic [7:0] f, logic [7:0] en, int ph, logic [3:0] hs);
        logic crit, defr, rel;
        crit = |(f & en & CRIT);
        defr = |(f & en & DEFR);
        rel  = (ph == 2) || (ph == 0 && hs == 4'd0);
        return !(crit || (defr && rel));
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_flags <= '0;
            m_phase <= 0;
        end else begin
            logic pend;
            pend = |(m_flags & evt_en & DEFR);
            m_flags <= (m_flags & ~flag_clr) | evt_pulse;
            case (m_phase)
                0: if (pend) begin
                       if (hold_sel == 4'd0) m_phase <= 2;
                       else begin m_phase <= 1; m_start <= cyc; m_win <= int'(hold_sel); end
                   end
                1: if (!pend) m_phase <= 0;
                   else if (cyc - m_start == m_win * DIV) m_phase <= 2;
                2: if (!pend) m_phase <= 0;
                default: m_phase <= 0;
            endcase
        end
    end

    // Per-cycle comparison of both outputs against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic exp_irq;
            exp_irq = model_irq_n(m_flags, evt_en, m_phase, hold_sel);
            n_chk++;
            if (evt_flags !== m_flags) begin
                n_bad++;
                $display("FAIL R1 flags cyc=%0d actual=%b expected=%b", cyc, evt_flags, m_flags);
            end
            n_chk++;
            if (irq_n !== exp_irq) begin
                n_bad++;
                $display("FAIL R4/R7 irq_n cyc=%0d actual=%b expected=%b", cyc, irq_n, exp_irq);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pulse events once and count negedges until irq_n is low (cap at lim)
    task automatic fire_time(logic [7:0] m, int lim, output int lat);
        @(negedge clk);
        evt_pulse = m;
        lat = 0;
        do begin
            @(negedge clk);
            evt_pulse = '0;
            lat++;
        end while (irq_n && lat < lim);
    endtask

    task automatic clear_all();
        @(negedge clk);
        flag_clr = 8'hFF;
        @(negedge clk);
        flag_clr = '0;
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int lat;
        int seed;
        seed = 32'h5EED_0101;
        void'($urandom(seed));

        // R2: reset state
        repeat (3) @(negedge clk);
        chk("R2 flags", evt_flags == '0, int'(evt_flags), 0);
        chk("R2 irq_n", irq_n == 1'b1, int'(irq_n), 1);
        rst_n = 1'b1;
        evt_en = 8'hFF;
        @(negedge clk);

        // R3: critical bit 1 with a long hold-off still asserts after one clock
        hold_sel = 4'd9;
        fire_time(8'b0000_0010, 200, lat);
        chk("R3 critical latency", lat == 1, lat, 1);
        clear_all();

        // R4: deferrable detect (bit 4), N=3
        hold_sel = 4'd3;
        fire_time(8'b0001_0000, 200, lat);
        chk("R4 defer latency N=3", lat == 3 * DIV + 2, lat, 3 * DIV + 2);
        clear_all();

        // R4: boundary N=15
        hold_sel = 4'd15;
        fire_time(8'b1000_0000, 400, lat);
        chk("R4 defer latency N=15", lat == 15 * DIV + 2, lat, 15 * DIV + 2);

        // R7: once released, a further deferrable event shows at once
        fire_time(8'b0000_1000, 200, lat);
        chk("R7 released passthrough", lat == 1, lat, 1);
        clear_all();
        chk("R7 cleared irq_n high", irq_n == 1'b1, int'(irq_n), 1);
        hold_sel = 4'd2;
        fire_time(8'b0010_0000, 200, lat);
        chk("R7 new full window", lat == 2 * DIV + 2, lat, 2 * DIV + 2);
        clear_all();

        // R5: zero selector disables deferral
        hold_sel = 4'd0;
        fire_time(8'b0000_0100, 200, lat);
        chk("R5 zero-sel latency", lat == 1, lat, 1);
        clear_all();

        // R8: selector change mid-window does not alter that window
        hold_sel = 4'd4;
        @(negedge clk);
        evt_pulse = 8'b0100_0000;
        @(negedge clk);
        evt_pulse = '0;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        hold_sel = 4'd1;
        while (irq_n && lat < 200) begin @(negedge clk); lat++; end
        chk("R8 window kept", lat == 4 * DIV + 2, lat, 4 * DIV + 2);
        clear_all();
        hold_sel = 4'd1;
        fire_time(8'b0100_0000, 200, lat);
        chk("R8 next window uses new sel", lat == DIV + 2, lat, DIV + 2);
        clear_all();

        // R6: disabled flag latches but is silent, even with zero selector
        hold_sel = 4'd0;
        evt_en = 8'b1111_1110;
        fire_time(8'b0000_0001, 30, lat);
        chk("R6 disabled critical silent", irq_n == 1'b1, int'(irq_n), 1);
        chk("R6 disabled flag latched", evt_flags[0] == 1'b1, int'(evt_flags[0]), 1);
        evt_en = 8'b0000_0011;
        hold_sel = 4'd2;
        fire_time(8'b0000_1000, 40, lat);
        chk("R6 disabled deferrable silent", irq_n == 1'b0 && lat == 1, lat, 1);
        flag_clr = 8'b0000_0001;
        @(negedge clk);
        flag_clr = '0;
        @(negedge clk);
        chk("R9 no enabled flag irq high", irq_n == 1'b1, int'(irq_n), 1);
        evt_en = 8'hFF;
        lat = 0;
        while (irq_n && lat < 200) begin @(negedge clk); lat++; end
        chk("R6 window starts on enable", lat == 2 * DIV + 1, lat, 2 * DIV + 1);
        clear_all();

        // R1: set wins over clear in the same cycle
        @(negedge clk);
        evt_pulse = 8'b0010_0000;
        flag_clr  = 8'b0010_0000;
        @(negedge clk);
        evt_pulse = '0;
        flag_clr  = '0;
        chk("R1 set beats clear", evt_flags[5] == 1'b1, int'(evt_flags[5]), 1);
        clear_all();

        // Random phase, model-checked each cycle
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            evt_pulse = (($urandom % 8) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            flag_clr  = (($urandom % 12) == 0) ? 8'($urandom) : 8'h00;
            if (($urandom % 97) == 0) evt_en = 8'($urandom) | 8'h0C;
            if (($urandom % 53) == 0) hold_sel = 4'($urandom % 5);
            if (i == 3000) begin
                rst_n = 1'b0;
                @(negedge clk);
                chk("R2 mid-run reset irq_n", irq_n == 1'b1, int'(irq_n), 1);
                rst_n = 1'b1;
            end
        end
        evt_pulse = '0;
        flag_clr = '0;
        repeat (5) @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule